// File: doc/BRIEF.md
# Two-Phase Frame Ring Pointer Manager

This block keeps the bookkeeping for a circular buffer of fixed-size frames. The number of frames is a power of two. The frame storage and the data movement sit outside the block. The block holds four frame pointers: two for the producer side and two for the consumer side.

On the producer side, a reserve pointer marks space that has been handed out for filling, and a publish pointer marks space that holds finished data. On the consumer side, an inspect pointer marks data that has been handed out for reading, and a release pointer marks space that has been given back. With these pointers a caller can reserve a region before it fills it, and inspect a region before it frees it.

Operations come in two sizes:
- Single-frame reads and writes move a variable number of frames. The grant is cut short at the wrap point, so each grant covers one contiguous region.
- Block-sized steps (prepare, publish, inspect, release) each move one group of 16 frames. An extra operation rewinds the consumer to a group boundary.

Each operation returns a frame offset relative to a base, a granted frame count and a success flag. Four occupancy counts are always available.

Top module: `frame_ring_ptrs`

## Requirements
- R1: After synchronous reset, all four pointers are zero. The counts read reserved=0, filled=0, unread=0 and spare=RING_FRAMES-1, and `done` is low.
- R2: All pointer arithmetic is modulo RING_FRAMES. The counts are computed as follows:
  - reserved = (wr_resv − rd_rel)
  - filled = (wr_pub − rd_rel)
  - unread = (wr_pub − rd_insp)
- R3: spare = (rd_rel − wr_resv − 1) modulo RING_FRAMES, so one frame always stays unused.
- R4: `op_code`=0 (frame write) grants the smallest of three values: the request, spare, and RING_FRAMES − wr_pub. It returns offset BASE+wr_pub and sets both producer pointers to wr_pub+grant. `ok` is set when the grant is non-zero.
- R5: `op_code`=1 (frame read) grants the smallest of three values: the request, unread, and RING_FRAMES − rd_insp. It returns offset BASE+rd_insp and sets both consumer pointers to rd_insp+grant. `ok` is set when the grant is non-zero.
- R6: `op_code`=2 (group prepare) succeeds only when spare ≥ 16. On success it returns `ok`=1, grant 16 and offset BASE+wr_resv, then advances wr_resv by 16. On failure it returns `ok`=0, grant 0 and offset 0, and no pointer moves.
- R7: `op_code`=3 (group publish) advances wr_pub by 16 and returns `ok`=1, grant 0 and offset 0.
- R8: `op_code`=4 (group inspect) succeeds only when unread ≥ 16. On success it returns `ok`=1, grant 16 and offset BASE+rd_insp, then advances rd_insp by 16. On failure it returns `ok`=0, grant 0 and offset 0, and no pointer moves.
- R9: `op_code`=5 (group release) advances rd_rel by 16 and returns `ok`=1, grant 0 and offset 0.
- R10: `op_code`=6 (rewind) sets both consumer pointers to wr_pub rounded down to a multiple of 16. It returns `ok`=1, grant 0 and offset 0.
- R11: Each cycle with `op_valid` high accepts one operation. The results (`done`, `ok`, `grant_frames`, `grant_ofs`) are registered and appear one cycle later, with `done` high for exactly that cycle.
  - When `op_valid` is low, no pointer moves and `done` stays low.
  - `op_code`=7 is reserved: it pulses `done` with `ok`=0, grant 0 and offset 0, and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request this cycle |
| op_code | input | 3 | Operation selector (see R4–R11) |
| req_frames | input | PW+1 | Requested frames for frame read/write |
| done | output | 1 | One-cycle pulse: results valid |
| ok | output | 1 | Operation succeeded / granted non-zero |
| grant_frames | output | PW+1 | Frames granted |
| grant_ofs | output | OFS_W | Base-relative frame offset of the grant |
| cnt_reserved | output | PW | Producer-reserved frames |
| cnt_filled | output | PW | Published frames not yet released |
| cnt_unread | output | PW | Published frames not yet inspected |
| cnt_spare | output | PW | Frames free for reservation |

## Verification
Some behaviours are checked by assertions on every cycle:
- the `done` pulse follows each accepted operation and never appears without one;
- frame grants never exceed the request or the available count, and never run past the wrap point;
- a successful prepare raises the reserved count by exactly one group, and a refused prepare only occurs with fewer than 16 spare frames;
- a rewind leaves fewer than 16 unread frames.

Other behaviours can only be shown by the bench's scenarios: the exact granted values and offsets, pointer wrap-around over many operations, the reserved opcode, idle cycles, and agreement of all four counts with an arithmetic model.

// File: rtl/ring_ptr_pkg.sv
`timescale 1ns/1ps
package ring_ptr_pkg;
  typedef enum logic [2:0] {
    OP_FWRITE  = 3'd0,
    OP_FREAD   = 3'd1,
    OP_GPREP   = 3'd2,
    OP_GPUB    = 3'd3,
    OP_GINSP   = 3'd4,
    OP_GREL    = 3'd5,
    OP_REWIND  = 3'd6,
    OP_RSVD    = 3'd7
  } ring_op_e;
endpackage

// File: rtl/ring_occupancy.sv
`timescale 1ns/1ps
module ring_occupancy #(
  parameter int PW = 7
) (
  input  logic [PW-1:0] wr_resv,
  input  logic [PW-1:0] wr_pub,
  input  logic [PW-1:0] rd_insp,
  input  logic [PW-1:0] rd_rel,
  output logic [PW-1:0] reserved,
  output logic [PW-1:0] filled,
  output logic [PW-1:0] unread,
  output logic [PW-1:0] spare
);
  // PW-bit subtraction wraps at the ring length (power of two).
  always_comb begin
    reserved = wr_resv - rd_rel;
    filled   = wr_pub - rd_rel;
    unread   = wr_pub - rd_insp;
    spare    = rd_rel - wr_resv - PW'(1);
  end
endmodule

// File: rtl/ring_clamp.sv
`timescale 1ns/1ps
module ring_clamp #(
  parameter int PW = 7,
  localparam int CW = PW + 1
) (
  input  logic [CW-1:0] req,
  input  logic [PW-1:0] avail,
  input  logic [PW-1:0] ptr,
  output logic [CW-1:0] grant
);
  localparam logic [CW-1:0] SPAN = CW'(1) << PW;
  logic [CW-1:0] room;
  logic [CW-1:0] lim;

  always_comb begin
    room  = SPAN - {1'b0, ptr};
    lim   = ({1'b0, avail} < room) ? {1'b0, avail} : room;
    grant = (req < lim) ? req : lim;
  end
endmodule

// File: rtl/frame_ring_ptrs.sv
`timescale 1ns/1ps
module frame_ring_ptrs
  import ring_ptr_pkg::*;
#(
  parameter int RING_FRAMES = 128,
  parameter int GROUP       = 16,
  parameter int BASE        = 0,
  parameter int OFS_W       = 16,
  localparam int PW = $clog2(RING_FRAMES),
  localparam int CW = PW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [CW-1:0]    req_frames,
  output logic             done,
  output logic             ok,
  output logic [CW-1:0]    grant_frames,
  output logic [OFS_W-1:0] grant_ofs,
  output logic [PW-1:0]    cnt_reserved,
  output logic [PW-1:0]    cnt_filled,
  output logic [PW-1:0]    cnt_unread,
  output logic [PW-1:0]    cnt_spare
);
  localparam logic [PW-1:0]    STEP   = PW'(GROUP);
  localparam logic [PW-1:0]    ALIGN  = ~PW'(GROUP - 1);
  localparam logic [CW-1:0]    STEP_C = CW'(GROUP);
  localparam logic [OFS_W-1:0] BASE_O = OFS_W'(BASE);

  logic [PW-1:0] wr_resv, wr_pub, rd_insp, rd_rel;
  logic [CW-1:0] wr_grant, rd_grant;

  ring_occupancy #(.PW(PW)) u_occ (
    .wr_resv (wr_resv),
    .wr_pub  (wr_pub),
    .rd_insp (rd_insp),
    .rd_rel  (rd_rel),
    .reserved(cnt_reserved),
    .filled  (cnt_filled),
    .unread  (cnt_unread),
    .spare   (cnt_spare)
  );

  ring_clamp #(.PW(PW)) u_wr_clamp (
    .req  (req_frames),
    .avail(cnt_spare),
    .ptr  (wr_pub),
    .grant(wr_grant)
  );

  ring_clamp #(.PW(PW)) u_rd_clamp (
    .req  (req_frames),
    .avail(cnt_unread),
    .ptr  (rd_insp),
    .grant(rd_grant)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_resv      <= '0;
      wr_pub       <= '0;
      rd_insp      <= '0;
      rd_rel       <= '0;
      done         <= 1'b0;
      ok           <= 1'b0;
      grant_frames <= '0;
      grant_ofs    <= '0;
    end else begin
      done         <= op_valid;
      ok           <= 1'b0;
      grant_frames <= '0;
      grant_ofs    <= '0;
      if (op_valid) begin
        case (op_code)
          OP_FWRITE: begin
            wr_resv      <= wr_pub + wr_grant[PW-1:0];
            wr_pub       <= wr_pub + wr_grant[PW-1:0];
            grant_frames <= wr_grant;
            ok           <= (wr_grant != '0);
            grant_ofs    <= BASE_O + OFS_W'(wr_pub);
          end
          OP_FREAD: begin
            rd_insp      <= rd_insp + rd_grant[PW-1:0];
            rd_rel       <= rd_insp + rd_grant[PW-1:0];
            grant_frames <= rd_grant;
            ok           <= (rd_grant != '0);
            grant_ofs    <= BASE_O + OFS_W'(rd_insp);
          end
          OP_GPREP: begin
            if (cnt_spare >= STEP) begin
              wr_resv      <= wr_resv + STEP;
              grant_frames <= STEP_C;
              ok           <= 1'b1;
              grant_ofs    <= BASE_O + OFS_W'(wr_resv);
            end
          end
          OP_GPUB: begin
            wr_pub <= wr_pub + STEP;
            ok     <= 1'b1;
          end
          OP_GINSP: begin
            if (cnt_unread >= STEP) begin
              rd_insp      <= rd_insp + STEP;
              grant_frames <= STEP_C;
              ok           <= 1'b1;
              grant_ofs    <= BASE_O + OFS_W'(rd_insp);
            end
          end
          OP_GREL: begin
            rd_rel <= rd_rel + STEP;
            ok     <= 1'b1;
          end
          OP_REWIND: begin
            rd_insp <= wr_pub & ALIGN;
            rd_rel  <= wr_pub & ALIGN;
            ok      <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> done); // R11
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !done); // R11
  AST_WRITE_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (done && $past(op_code) == OP_FWRITE) |->
      (grant_frames <= $past(req_frames) && grant_frames <= {1'b0, $past(cnt_spare)})); // R4
  AST_READ_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (done && $past(op_code) == OP_FREAD) |->
      (grant_frames <= $past(req_frames) && grant_frames <= {1'b0, $past(cnt_unread)})); // R5
  AST_NO_WRAP_CROSS: assert property (@(posedge clk) disable iff (rst)
    (done && ($past(op_code) == OP_FWRITE || $past(op_code) == OP_FREAD)) |->
      (int'(grant_ofs) - BASE + int'(grant_frames) <= RING_FRAMES)); // R4 R5
  AST_PREP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (done && ok && $past(op_code) == OP_GPREP) |->
      (cnt_reserved == $past(cnt_reserved) + STEP)); // R6
  AST_PREP_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (done && !ok && $past(op_code) == OP_GPREP) |->
      ($past(cnt_spare) < STEP && $stable(cnt_reserved))); // R6
  AST_REWIND_RESIDUE: assert property (@(posedge clk) disable iff (rst)
    (done && $past(op_code) == OP_REWIND) |->
      (cnt_unread < STEP && cnt_unread == cnt_filled)); // R10
endmodule

// File: tb/frame_ring_ptrs_bench.sv
`timescale 1ns/1ps
module frame_ring_ptrs_bench;
  localparam int RING = 32;
  localparam int GRP  = 16;
  localparam int BASE = 64;
  localparam int OW   = 16;
  localparam int PW   = 5;
  localparam int CW   = 6;
  localparam int M    = RING - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 1'b0;
  logic [2:0]    op_code = 3'd0;
  logic [CW-1:0] req_frames = '0;
  logic          done, ok;
  logic [CW-1:0] grant_frames;
  logic [OW-1:0] grant_ofs;
  logic [PW-1:0] cnt_reserved, cnt_filled, cnt_unread, cnt_spare;

  int total = 0;
  int bad = 0;
  int m_wr = 0, m_wp = 0, m_ri = 0, m_rr = 0;

  always #4 clk = ~clk;

  frame_ring_ptrs #(.RING_FRAMES(RING), .GROUP(GRP), .BASE(BASE), .OFS_W(OW)) u_frame_ring_ptrs (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .req_frames(req_frames),
    .done(done), .ok(ok), .grant_frames(grant_frames), .grant_ofs(grant_ofs),
    .cnt_reserved(cnt_reserved), .cnt_filled(cnt_filled),
    .cnt_unread(cnt_unread), .cnt_spare(cnt_spare)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int min3(input int a, input int b, input int c);
    int r = a;
    if (b < r) r = b;
    if (c < r) r = c;
    return r;
  endfunction

  function automatic string tag_of(input int code);
    case (code)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      5: return "R9";
      6: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check_counts();
    chk("R2", "reserved", int'(cnt_reserved), (m_wr - m_rr) & M);
    chk("R2", "filled",   int'(cnt_filled),   (m_wp - m_rr) & M);
    chk("R2", "unread",   int'(cnt_unread),   (m_wp - m_ri) & M);
    chk("R3", "spare",    int'(cnt_spare),    (m_rr - m_wr - 1) & M);
  endtask

  task automatic run_op(input int code, input int req);
    int e_ok = 0, e_g = 0, e_ofs = 0;
    int spare  = (m_rr - m_wr - 1) & M;
    int unread = (m_wp - m_ri) & M;
    case (code)
      0: begin
        e_g = min3(req, spare, RING - m_wp); e_ok = (e_g != 0); e_ofs = BASE + m_wp;
        m_wp = (m_wp + e_g) & M; m_wr = m_wp;
      end
      1: begin
        e_g = min3(req, unread, RING - m_ri); e_ok = (e_g != 0); e_ofs = BASE + m_ri;
        m_ri = (m_ri + e_g) & M; m_rr = m_ri;
      end
      2: if (spare >= GRP) begin
        e_ok = 1; e_g = GRP; e_ofs = BASE + m_wr; m_wr = (m_wr + GRP) & M;
      end
      3: begin e_ok = 1; m_wp = (m_wp + GRP) & M; end
      4: if (unread >= GRP) begin
        e_ok = 1; e_g = GRP; e_ofs = BASE + m_ri; m_ri = (m_ri + GRP) & M;
      end
      5: begin e_ok = 1; m_rr = (m_rr + GRP) & M; end
      6: begin e_ok = 1; m_ri = m_wp & ~(GRP - 1); m_rr = m_ri; end
      default: ;
    endcase
    @(negedge clk);
    op_valid = 1'b1; op_code = 3'(code); req_frames = CW'(req);
    @(negedge clk);
    op_valid = 1'b0;
    chk("R11", "done", int'(done), 1);
    chk(tag_of(code), "ok", int'(ok), e_ok);
    chk(tag_of(code), "grant", int'(grant_frames), e_g);
    chk(tag_of(code), "offset", int'(grant_ofs), e_ofs);
    check_counts();
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk("R11", "done idle", int'(done), 0);
    check_counts();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R11 watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "done", int'(done), 0);
    chk("R1", "reserved", int'(cnt_reserved), 0);
    chk("R1", "filled", int'(cnt_filled), 0);
    chk("R1", "unread", int'(cnt_unread), 0);
    chk("R1", "spare", int'(cnt_spare), RING - 1);

    run_op(4, 0);   // R8 inspect refused on empty ring
    run_op(2, 0);   // R6 prepare succeeds
    run_op(2, 0);   // R6 prepare refused (15 spare)
    run_op(3, 0);   // R7 publish
    run_op(4, 0);   // R8 inspect succeeds
    run_op(5, 0);   // R9 release
    idle_check();   // R11 idle leaves state
    run_op(7, 5);   // R11 reserved code
    idle_check();

    // R4/R5 request sweep across pointer positions and wrap point
    for (int r = 0; r <= RING; r++) begin
      run_op(0, r);
      run_op(1, (r * 3) % (RING + 1));
    end
    run_op(0, 21);
    run_op(6, 0);   // R10 rewind to group boundary
    run_op(1, RING);

    // mixed deterministic sequence over all codes
    for (int i = 0; i < 2000; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      run_op(int'((seed >> 16) % 8), int'((seed >> 8) % (RING + 1)));
      if (i % 97 == 0) idle_check();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule